// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside a memory port and decides, for every write that reaches the memory, whether the write may proceed. It watches a request stream in which each request carries an address, the ID of the hardware context that issued it, and one of four kinds: ordinary load, load-linked, ordinary store or store-conditional. A load-linked leaves a reservation behind. A later store-conditional from the same context to the same granule succeeds only while that reservation is still present.

Reservations are kept in a small shared table. Each entry holds a 16-byte granule address and a context ID. Any store that writes a granule removes every reservation on that granule, whichever context holds it. The table keeps its entries in age order. When it is full, a new load-linked pushes out the oldest entry.

The memory itself, the data path and any latency modelling are outside the block. The block only returns, one cycle after each accepted request, a write-enable decision and a store-conditional result.

Top module: `llsc_monitor`

## Requirements
- R1: Address bits [3:0] are ignored: reservations are recorded and compared on the granule address `req_addr[ADDR_W-1:4]`.
- R2: A load-linked (`req_kind` = 2'b01) records a reservation for `req_ctx` at its granule. A later store-conditional (`req_kind` = 2'b11) from the same context to the same granule returns `rsp_wr_en`=1 and `rsp_sc_ok`=1.
- R3: A store-conditional fails, with `rsp_wr_en`=0 and `rsp_sc_ok`=0, when no entry matches both its granule and its context. This includes an empty table, and a reservation on the same granule held by another context.
- R4: An ordinary store (`req_kind` = 2'b10) always returns `rsp_wr_en`=1 and `rsp_sc_ok`=0. It removes every reservation on its granule, whichever context holds it.
- R5: A successful store-conditional removes every reservation on its granule, including those held by other contexts. A failed store-conditional changes no reservation.
- R6: A load-linked from a context replaces that context's earlier reservation, so no two entries ever hold the same context.
- R7: When all ENTRIES slots are in use and a load-linked comes from a context with no entry, the oldest reservation is dropped. The next store-conditional from the dropped context then fails.
- R8: An ordinary load (`req_kind` = 2'b00) returns `rsp_wr_en`=0 and `rsp_sc_ok`=0 and leaves the table unchanged.
- R9: `req_ready` is always 1. A request is accepted when `req_valid` is 1. `rsp_valid`, `rsp_wr_en` and `rsp_sc_ok` are registered and describe the request accepted in the previous cycle. When no request was accepted, all three are 0.
- R10: A synchronous reset (`rst`=1) empties the table and clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ctx | input | CTX_W | Issuing context ID |
| req_kind | input | 2 | 00 load, 01 load-linked, 10 store, 11 store-conditional |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_wr_en | output | 1 | The write of that request may proceed |
| rsp_sc_ok | output | 1 | Store-conditional result (1 = success) |

## Verification
The checker watches the table's shape and the response outputs on every cycle. It checks the following:
- the table stays packed in age order and never holds two entries for one context;
- a success result always comes with a write-enable;
- stores always write, and loads never do;
- the response appears exactly one cycle after acceptance;
- reset empties the table.

Whether a given store-conditional should succeed depends on the history of loads-linked, stores and evictions. Only the bench's scenarios can show that: granule aliasing through the low bits, cross-context clearing, replacement of a context's own reservation, and oldest-first eviction. The bench compares these against its queue-based reference model on every clock.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int CTX_W    = 3,
  parameter int ENTRIES  = 4,
  parameter int GRAN_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic              rsp_wr_en,
  output logic              rsp_sc_ok
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0] v_q, n_v, hit_gran, hit_ctx, kill;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TAG_W-1:0]   n_tag [ENTRIES];
  logic [CTX_W-1:0]   ctx_q [ENTRIES];
  logic [CTX_W-1:0]   n_ctx [ENTRIES];
  logic [CNT_W-1:0]   cnt;

  wire [TAG_W-1:0] req_tag = req_addr[ADDR_W-1:GRAN_LSB];
  wire fire  = req_valid & req_ready;
  wire is_ll = req_kind == 2'b01;
  wire is_st = req_kind == 2'b10;
  wire is_sc = req_kind == 2'b11;
  wire sc_ok = |(hit_gran & hit_ctx);

  assign req_ready = 1'b1;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit_gran[i] = v_q[i] && (tag_q[i] == req_tag);
      hit_ctx[i]  = v_q[i] && (ctx_q[i] == req_ctx);
    end
  end

  assign kill = !fire ? '0 :
                is_ll ? hit_ctx :
                (is_st || (is_sc && sc_ok)) ? hit_gran : '0;

  always_comb begin
    n_v = '0;
    cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      n_tag[i] = tag_q[i];
      n_ctx[i] = ctx_q[i];
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i] && !kill[i]) begin
        n_tag[cnt] = tag_q[i];
        n_ctx[cnt] = ctx_q[i];
        n_v[cnt]   = 1'b1;
        cnt        = cnt + CNT_W'(1);
      end
    end
    if (fire && is_ll) begin
      if (cnt == CNT_W'(ENTRIES)) begin
        for (int j = 0; j < ENTRIES - 1; j++) begin
          n_tag[j] = n_tag[j+1];
          n_ctx[j] = n_ctx[j+1];
        end
        n_tag[ENTRIES-1] = req_tag;
        n_ctx[ENTRIES-1] = req_ctx;
      end else begin
        n_tag[cnt] = req_tag;
        n_ctx[cnt] = req_ctx;
        n_v[cnt]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= '0;
      rsp_valid <= 1'b0;
      rsp_wr_en <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      v_q       <= n_v;
      rsp_valid <= fire;
      rsp_wr_en <= fire && (is_st || (is_sc && sc_ok));
      rsp_sc_ok <= fire && is_sc && sc_ok;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      tag_q[i] <= n_tag[i];
      ctx_q[i] <= n_ctx[i];
    end
  end
endmodule

module llsc_monitor_chk #(
  parameter int CTX_W   = 3,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               fire,
  input logic [1:0]         req_kind,
  input logic               rsp_valid,
  input logic               rsp_wr_en,
  input logic               rsp_sc_ok,
  input logic [ENTRIES-1:0] v_q,
  input logic [CTX_W-1:0]   ctx_q [ENTRIES]
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (v_q[i] && v_q[j] && ctx_q[i] == ctx_q[j]) dup = 1'b1;
  end

  // R9
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);
  // R9
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid && !rsp_wr_en && !rsp_sc_ok);
  // R5
  ok_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_sc_ok |-> rsp_wr_en && rsp_valid);
  // R4
  store_writes_chk: assert property (@(posedge clk) disable iff (rst)
    fire && req_kind == 2'b10 |=> rsp_wr_en && !rsp_sc_ok);
  // R8
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !req_kind[1] |=> !rsp_wr_en && !rsp_sc_ok);
  // R7
  packed_table_chk: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, v_q} + 1'b1) & {1'b0, v_q}) == '0);
  // R6
  one_per_ctx_chk: assert property (@(posedge clk) disable iff (rst)
    !dup);
  // R10
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> v_q == '0 && !rsp_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.CTX_W(CTX_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .fire(req_valid & req_ready), .req_kind(req_kind),
  .rsp_valid(rsp_valid), .rsp_wr_en(rsp_wr_en), .rsp_sc_ok(rsp_sc_ok),
  .v_q(v_q), .ctx_q(ctx_q)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [1:0] LD = 2'b00, LL = 2'b01, ST = 2'b10, SC = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [2:0] req_ctx = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_wr_en, rsp_sc_ok;
  int total = 0, bad = 0;
  int qa[$], qc[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ctx(req_ctx), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_wr_en(rsp_wr_en), .rsp_sc_ok(rsp_sc_ok)
  );

  task automatic chk(input string tag, input logic v, input logic w, input logic o);
    total++;
    if (rsp_valid !== v || rsp_wr_en !== w || rsp_sc_ok !== o || req_ready !== 1'b1) begin
      bad++;
      $display("FAIL %s: got v=%b wr=%b ok=%b rdy=%b exp v=%b wr=%b ok=%b rdy=1",
               tag, rsp_valid, rsp_wr_en, rsp_sc_ok, req_ready, v, w, o);
    end
  endtask

  task automatic drop_gran(input int g);
    for (int i = qa.size() - 1; i >= 0; i--)
      if (qa[i] == g) begin qa.delete(i); qc.delete(i); end
  endtask

  // Drive at negedge, update the model, compare after the next posedge.
  task automatic op(input logic [1:0] k, input int a, input int c, input string tag,
                    input int exp_ok = -1);
    int g;
    logic w, o, hit;
    g = a >>> 4;
    w = 1'b0; o = 1'b0; hit = 1'b0;
    req_valid = 1'b1; req_kind = k; req_addr = a; req_ctx = c[2:0];
    case (k)
      LL: begin
        for (int i = qc.size() - 1; i >= 0; i--)
          if (qc[i] == c) begin qa.delete(i); qc.delete(i); end
        if (qa.size() == N) begin void'(qa.pop_front()); void'(qc.pop_front()); end
        qa.push_back(g); qc.push_back(c);
      end
      ST: begin w = 1'b1; drop_gran(g); end
      SC: begin
        foreach (qa[i]) if (qa[i] == g && qc[i] == c) hit = 1'b1;
        if (hit) begin w = 1'b1; o = 1'b1; drop_gran(g); end
      end
      default: ;
    endcase
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, 1'b1, w, o);
    if (exp_ok >= 0) begin
      total++;
      if (rsp_sc_ok !== exp_ok[0]) begin
        bad++;
        $display("FAIL %s (scenario): got ok=%b exp ok=%0d", tag, rsp_sc_ok, exp_ok);
      end
    end
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(negedge clk);
    chk(tag, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    idle("R9 idle");

    op(SC, 'h100, 1, "R3 sc on empty table", 0);
    op(ST, 'h100, 1, "R4 store on empty table");
    op(LL, 'h100, 1, "R2 ll");
    op(LD, 'h100, 2, "R8 load");
    op(SC, 'h10C, 1, "R1 R2 sc within granule", 1);
    op(SC, 'h100, 1, "R5 sc after own success", 0);

    op(LL, 'h200, 2, "R2 ll ctx2");
    op(SC, 'h200, 3, "R3 sc other ctx", 0);
    op(SC, 'h210, 2, "R1 R3 sc next granule", 0);
    op(SC, 'h200, 2, "R5 failed sc kept entry", 1);

    op(LL, 'h300, 1, "R4 ll ctx1");
    op(LL, 'h304, 2, "R4 ll ctx2");
    op(ST, 'h30F, 5, "R4 store clears granule");
    op(SC, 'h300, 1, "R4 ctx1 cleared", 0);
    op(SC, 'h300, 2, "R4 ctx2 cleared", 0);

    op(LL, 'h400, 1, "R5 ll ctx1");
    op(LL, 'h400, 2, "R5 ll ctx2");
    op(SC, 'h408, 1, "R5 sc ctx1", 1);
    op(SC, 'h400, 2, "R5 ctx2 lost by sc", 0);

    op(LL, 'h500, 3, "R6 ll first");
    op(LL, 'h600, 3, "R6 ll replaces");
    op(SC, 'h500, 3, "R6 old gone", 0);
    op(SC, 'h600, 3, "R6 new held", 1);

    for (int c = 0; c < 5; c++) op(LL, 'h700 + c * 'h10, c, "R7 fill");
    op(SC, 'h700, 0, "R7 oldest evicted", 0);
    op(SC, 'h710, 1, "R7 next kept", 1);
    op(LD, 'h720, 2, "R8 load no effect");
    op(SC, 'h720, 2, "R8 entry survives load", 1);

    op(LL, 'h800, 4, "R10 ll before reset");
    rst = 1'b1;
    @(negedge clk);
    chk("R10 in reset", 1'b0, 1'b0, 1'b0);
    rst = 1'b0; qa.delete(); qc.delete();
    op(SC, 'h800, 4, "R10 reset emptied table", 0);
    idle("R9 idle end");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule